// File: doc/BRIEF.md
# SPI Flash Page Erase Sequencer

This block is an SPI master that clears a single page of an attached serial flash and stays busy until the device reports that the erase has finished. A user pulses `start` with a page number. The block then selects the flash and shifts out a four-byte erase frame: the erase opcode followed by a 24-bit address in which only the page field is populated. It releases chip select so the device begins the erase, and after that it issues a series of short status transactions. Each status transaction sends a status opcode and reads back one byte.

The most significant bit of each status byte indicates readiness: 1 means the page is clear, 0 means the erase is still running. When a poll returns the bit at 1, the block pulses `done` and goes idle. If a parameterised number of polls all return 0, the block raises `timeout_err` and goes idle instead. The following are all parameters: the serial clock divider, the width of the page field, the bit position of the page field inside the address, the status opcode and the poll limit. The default poll limit covers an erase time of at least 35 ms at the default divider.

Top module: `spi_page_erase`

## Requirements
- R1: After reset, `cs_n` and `sclk` are 1 and `busy`, `done` and `timeout_err` are 0. They stay that way until a start is accepted.
- R2: While idle, a `start` pulse is accepted. On the next clock `busy` is 1, `cs_n` is 0, `sclk` is still 1, and `timeout_err` is cleared.
- R3: The first transaction has exactly 32 serial clocks. It carries opcode 0x81 followed by the address bytes high, middle, low, each most significant bit first. MOSI changes only when `sclk` falls and never while `sclk` is high inside a transaction.
- R4: The page number occupies address bits `[PAGE_LSB +: PAGE_W]`. Every other address bit is 0.
- R5: After the erase frame, `cs_n` returns to 1. Each status poll is then its own transaction of exactly 16 serial clocks. The first 8 bits are `STAT_OP`, and in the last 8 bits MISO is sampled on rising `sclk`, most significant bit first.
- R6: If status bit 7 (the first sampled response bit) is 1, `done` is high for exactly one clock. In that same cycle `busy` is 0 and `cs_n` is 1, and no further poll follows.
- R7: If `MAX_POLLS` consecutive polls return bit 7 = 0, `timeout_err` becomes 1, `busy` becomes 0 and `done` stays 0. `timeout_err` holds until the next accepted start.
- R8: A `start` pulse while `busy` is 1 is ignored. It does not alter the transaction sequence, and a page value presented with it has no effect.
- R9: `sclk` rests at 1 and toggles only while `cs_n` is 0.
- R10: Status bits 6..0 have no effect. Only bit 7 decides between continuing to poll and finishing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Erase request strobe |
| page | input | PAGE_W | Page number to erase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock pulse when the erase is confirmed |
| timeout_err | output | 1 | Poll limit reached without ready |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
Two events can coincide. The ready bit may first appear on the final permitted poll, which is also the cycle in which the timeout decision is made. The bench provokes this with a flash model that reports ready on exactly poll `MAX_POLLS`, and expects `done` with no timeout. It also runs the case one poll later and expects a timeout with no `done`. A second coincidence is a start strobe that arrives while a transaction is being shifted. The bench judges this by checking that the captured frames are unchanged and that only one completion event occurs.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;
   localparam logic [7:0] ERASE_OPCODE = 8'h81;
   localparam int         FRAME_BITS   = 32;
   localparam int         ADDR_BITS    = 24;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ERASE,
      SQ_TAIL,
      SQ_GAP,
      SQ_POLL,
      SQ_EVAL
   } seq_state_t;
endpackage

// File: rtl/spi_erase_tick.sv
module spi_erase_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   initial begin
      if (DIV < 1) $error("DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_every
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick <= 1'b0;
            else        tick <= run;
         end
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               tick <= 1'b0;
            end else if (!run) begin
               cnt  <= '0;
               tick <= 1'b0;
            end else if (cnt == CW'(DIV - 1)) begin
               cnt  <= '0;
               tick <= 1'b1;
            end else begin
               cnt  <= cnt + 1'b1;
               tick <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/spi_erase_shift.sv
module spi_erase_shift #(
   parameter int FRAME_W = 32,
   localparam int NBW = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [NBW-1:0]     nbits,
   input  logic               miso,
   output logic               sclk,
   output logic               mosi,
   output logic               rx_top,
   output logic               fin
);
   logic [FRAME_W-1:0] sr;
   logic [NBW-1:0]     left;
   logic               act;
   logic [7:0]         rx;

   assign rx_top = rx[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         left <= '0;
         act  <= 1'b0;
         sclk <= 1'b1;
         mosi <= 1'b0;
         rx   <= '0;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (load) begin
            sr   <= frame;
            left <= nbits;
            act  <= 1'b1;
            sclk <= 1'b1;
            mosi <= 1'b0;
         end else if (tick && act) begin
            if (sclk) begin
               sclk <= 1'b0;
               mosi <= sr[FRAME_W-1];
               sr   <= {sr[FRAME_W-2:0], 1'b0};
            end else begin
               sclk <= 1'b1;
               rx   <= {rx[6:0], miso};
               left <= left - 1'b1;
               if (left == NBW'(1)) begin
                  act <= 1'b0;
                  fin <= 1'b1;
               end
            end
         end
      end
   end

   // R9: an idle shifter leaves the clock high
   a_r9_shift_rest: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> sclk);
endmodule

// File: rtl/spi_page_erase.sv
module spi_page_erase
   import spi_erase_pkg::*;
#(
   parameter int          DIV       = 4,
   parameter int          PAGE_W    = 11,
   parameter int          PAGE_LSB  = 9,
   parameter logic [7:0]  STAT_OP   = 8'hD7,
   parameter int          MAX_POLLS = 16384
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PAGE_W-1:0] page,
   output logic              busy,
   output logic              done,
   output logic              timeout_err,
   output logic              cs_n,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   localparam int PCW = $clog2(MAX_POLLS + 1);
   localparam int NBW = $clog2(FRAME_BITS + 1);

   initial begin
      if (PAGE_W < 1 || PAGE_LSB < 0 || PAGE_LSB + PAGE_W > ADDR_BITS)
         $error("page field does not fit the address");
      if (MAX_POLLS < 1) $error("MAX_POLLS must be at least 1");
   end

   seq_state_t             st;
   logic                   in_poll;
   logic [PCW-1:0]         polls;
   logic                   tick, load, fin, rdy;
   logic [ADDR_BITS-1:0]   addr_w;
   logic [FRAME_BITS-1:0]  frame;
   logic [NBW-1:0]         nbits;

   always_comb begin
      addr_w = '0;
      addr_w[PAGE_LSB +: PAGE_W] = page;
   end

   always_comb begin
      load  = (st == SQ_IDLE && start) || (st == SQ_GAP && tick);
      frame = (st == SQ_IDLE) ? {ERASE_OPCODE, addr_w} : {STAT_OP, {ADDR_BITS{1'b0}}};
      nbits = (st == SQ_IDLE) ? NBW'(FRAME_BITS) : NBW'(16);
   end

   spi_erase_tick #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(st != SQ_IDLE), .tick(tick)
   );

   spi_erase_shift #(.FRAME_W(FRAME_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .frame(frame),
      .nbits(nbits), .miso(miso), .sclk(sclk), .mosi(mosi),
      .rx_top(rdy), .fin(fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= SQ_IDLE;
         busy        <= 1'b0;
         done        <= 1'b0;
         timeout_err <= 1'b0;
         cs_n        <= 1'b1;
         polls       <= '0;
         in_poll     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            SQ_IDLE: if (start) begin
               st          <= SQ_ERASE;
               busy        <= 1'b1;
               timeout_err <= 1'b0;
               cs_n        <= 1'b0;
               polls       <= '0;
               in_poll     <= 1'b0;
            end
            SQ_ERASE, SQ_POLL: if (fin) st <= SQ_TAIL;
            SQ_TAIL: if (tick) begin
               cs_n <= 1'b1;
               st   <= in_poll ? SQ_EVAL : SQ_GAP;
            end
            SQ_GAP: if (tick) begin
               cs_n    <= 1'b0;
               in_poll <= 1'b1;
               st      <= SQ_POLL;
            end
            SQ_EVAL: begin
               if (rdy) begin
                  done <= 1'b1;
                  busy <= 1'b0;
                  st   <= SQ_IDLE;
               end else if (polls == PCW'(MAX_POLLS - 1)) begin
                  timeout_err <= 1'b1;
                  busy        <= 1'b0;
                  st          <= SQ_IDLE;
               end else begin
                  polls <= polls + 1'b1;
                  st    <= SQ_GAP;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   // R1: the flash is selected only during a sequence
   a_r1_select_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);
   // R9: clock rests high while deselected
   a_r9_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);
   // R9: clock moves only while selected
   a_r9_clock_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |-> !cs_n);
   // R3: data held through the high phase of the serial clock
   a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && sclk && $past(sclk) && !$past(cs_n)) |-> $stable(mosi));
   // R6: completion lasts one clock with the flash released
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r6_done_released: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && cs_n));
   // R7: timeout and completion never coincide
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout_err));
endmodule

// File: tb/spi_page_erase_test.sv
module spi_page_erase_test;
   localparam int          DIV       = 2;
   localparam int          PW        = 11;
   localparam int          PL        = 9;
   localparam logic [7:0]  SOP       = 8'hD7;
   localparam int          MP        = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, start, busy, done, timeout_err, cs_n, sclk, mosi, miso;
   logic [PW-1:0] page_i;

   spi_page_erase #(.DIV(DIV), .PAGE_W(PW), .PAGE_LSB(PL), .STAT_OP(SOP),
                    .MAX_POLLS(MP)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .page(page_i), .busy(busy),
      .done(done), .timeout_err(timeout_err), .cs_n(cs_n), .sclk(sclk),
      .mosi(mosi), .miso(miso)
   );

   int checks = 0;
   int errors = 0;

   // flash model
   int          bitcnt = 0;
   logic [31:0] shreg = '0;
   logic [31:0] tx_data [16];
   int          tx_bits [16];
   int          ntx = 0;
   int          polls_done = 0;
   int          ready_after = 0;
   logic [6:0]  low7 = '0;

   always @(negedge cs_n) begin bitcnt = 0; shreg = '0; end
   always @(posedge sclk) if (cs_n === 1'b0) begin
      shreg = {shreg[30:0], mosi};
      bitcnt++;
   end
   always @(posedge cs_n) begin
      if (ntx < 16) begin tx_data[ntx] = shreg; tx_bits[ntx] = bitcnt; end
      ntx++;
      if (bitcnt == 16) polls_done++;
   end
   always @(negedge sclk) if (cs_n === 1'b0) begin
      logic [7:0] stat;
      stat = {(polls_done >= ready_after), low7};
      if (bitcnt >= 8 && bitcnt < 16) miso = stat[15 - bitcnt];
      else miso = 1'b0;
   end

   // port monitors
   int done_cnt = 0, done_bad = 0, proto = 0;
   logic p_done = 0, p_sclk = 1, p_cs = 1, p_mosi = 0;
   always @(negedge clk) if (rst_n) begin
      if (done) begin
         done_cnt++;
         if (busy || !cs_n || p_done) done_bad++;
      end
      if (!cs_n && !p_cs && sclk && p_sclk && mosi !== p_mosi) proto++;
      if (sclk !== p_sclk && cs_n && p_cs) proto++;
      p_done = done; p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_addr(input logic [PW-1:0] p);
      logic [23:0] a = '0;
      a[PL +: PW] = p;
      return a;
   endfunction

   task automatic run(input logic [PW-1:0] pg, input int ra, input logic [6:0] l7,
                      input bit poke);
      int exp_polls, lim;
      bit exp_to;
      ntx = 0; polls_done = 0; ready_after = ra; low7 = l7;
      done_cnt = 0; done_bad = 0; proto = 0;
      exp_to    = (ra >= MP);
      exp_polls = exp_to ? MP : ra + 1;
      @(negedge clk); page_i = pg; start = 1'b1;
      @(negedge clk); start = 1'b0;
      // R2 accept and R7 flag cleared
      chk(busy && !cs_n && sclk, "R2 start accepted", {busy, cs_n, sclk}, 3'b101);
      chk(!timeout_err, "R7 cleared on start", timeout_err, 0);
      if (poke) begin
         repeat (40) @(negedge clk);
         page_i = ~pg; start = 1'b1;
         @(negedge clk); start = 1'b0;
         chk(busy, "R8 busy kept", busy, 1);
      end
      lim = 0;
      while (busy && lim < 20000) begin @(negedge clk); lim++; end
      if (busy) begin
         chk(0, "R6 watchdog on run", lim, 0);
         return;
      end
      repeat (4) @(negedge clk);
      chk(ntx == 1 + exp_polls, "R5 transaction count", ntx, 1 + exp_polls);
      chk(tx_bits[0] == 32, "R3 erase frame length", tx_bits[0], 32);
      chk(tx_data[0] == {8'h81, exp_addr(pg)}, "R4 R3 erase frame",
          tx_data[0], {8'h81, exp_addr(pg)});
      for (int i = 1; i <= exp_polls && i < 16; i++) begin
         chk(tx_bits[i] == 16 && tx_data[i][15:8] == SOP, "R5 poll frame",
             {tx_bits[i], tx_data[i][15:0]}, {16, SOP, 8'h00});
      end
      chk(done_cnt == (exp_to ? 0 : 1), "R6 R10 done count", done_cnt, exp_to ? 0 : 1);
      chk(done_bad == 0, "R6 done shape", done_bad, 0);
      chk(timeout_err == exp_to, "R7 timeout flag", timeout_err, exp_to);
      chk(proto == 0 && cs_n && sclk, "R9 R3 serial protocol", proto, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      rst_n = 1'b0; start = 1'b0; page_i = '0; miso = 1'b0;
      repeat (3) @(negedge clk);
      chk(cs_n && sclk && !busy && !done && !timeout_err, "R1 reset state",
          {cs_n, sclk, busy, done, timeout_err}, 5'b11000);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(cs_n && sclk && !busy, "R1 idle after reset", {cs_n, sclk, busy}, 3'b110);

      run(11'h000, 0, 7'h00, 0);       // ready on first poll
      run(11'h7FF, MP - 1, 7'h7F, 0);  // ready on last permitted poll, noisy low bits (R10)
      run(11'h2A5, MP, 7'h7F, 0);      // one poll too many: timeout
      run(11'h155, 2, 7'h00, 1);       // start while busy (R8)
      run(11'h001, MP + 2, 7'h55, 0);  // timeout again, next run clears
      for (int k = 0; k < 10; k++) begin
         run(PW'($urandom), int'($urandom_range(0, MP + 1)), 7'($urandom), bit'($urandom_range(0, 1)));
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule